// File: doc/BRIEF.md
# Run-Time Programmable LFSR for Pseudo-Random Sequences and Serial CRC

This block is a linear feedback shift register whose feedback taps come from a polynomial register loaded at run time. One shared register serves two purposes, picked per step by a mode input. In pseudo-random mode it advances in Fibonacci form and presents its top bit as a serial output. In CRC mode it takes in one serial data bit per step and folds it into a checksum in Galois form. The running value is always visible on the result port.

The register is built from 8-bit slices. A parameter sets how many slices are joined. The joined slices act as one wider register, so a 16-bit polynomial behaves exactly as it would in a single monolithic 16-bit shift register. A seed write loads the register directly, which is also the only way out of the all-zero lock-up state in pseudo-random mode. A single enable bit gates all stepping. A per-cycle clock enable sets the pace of the steps.

Top module: `lfsr_seq_crc`

## Requirements
- R1: After synchronous reset the register and the polynomial are all zero, so `result` and `ser_out` read 0.
- R2: When `seed_wr` is high, the register takes `seed_wdata` at the next edge. This happens even if a step is requested in the same cycle.
- R3: In pseudo-random mode (`mode_sel`=0), each step shifts the register left by one. The new bit 0 is the XOR of all register bits whose polynomial bit is 1. `ser_out` always equals the register MSB.
- R4: In CRC mode (`mode_sel`=1), each step computes fb = MSB XOR `ser_din`. The register then becomes (register shifted left with 0 entering bit 0), XORed with the polynomial when fb is 1.
- R5: A step occurs only when `enable` and `clk_en` are both 1. Otherwise the register holds its value.
- R6: A polynomial write takes effect from the next step. A step in the same cycle as the write still uses the old polynomial. The write itself never changes the register.
- R7: In pseudo-random mode an all-zero register stays zero on every step until a seed is written.
- R8: With the default 16-bit width, polynomial 0xB400 and a nonzero seed, the pseudo-random sequence returns to its seed after exactly 65535 steps.
- R9: Slices join into one register of width SLICE_W*NUM_SLICES. The MSB of each slice shifts into bit 0 of the slice above it in both modes.
- R10: The mode is sampled on every step, so CRC and pseudo-random steps may be interleaved on the same register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; no stepping while low |
| clk_en | input | 1 | Step request for this cycle |
| mode_sel | input | 1 | 0 = pseudo-random, 1 = CRC |
| ser_din | input | 1 | Serial data bit for CRC mode |
| poly_wr | input | 1 | Polynomial write strobe |
| poly_wdata | input | SLICE_W*NUM_SLICES | Polynomial tap mask (x^W term implied) |
| seed_wr | input | 1 | Seed write strobe; loads the register |
| seed_wdata | input | SLICE_W*NUM_SLICES | Seed value |
| result | output | SLICE_W*NUM_SLICES | Current register / CRC result |
| ser_out | output | 1 | Register MSB, the pseudo-random bit stream |

## Verification
The bench targets the slice boundary. A design that dropped the carry from bit 7 into bit 8 would produce two short independent 8-bit sequences, and the full-period count would come out far below 65535. The bench also targets same-cycle collisions: a seed write against a step, and a polynomial write against a step. Getting the priority or the timing wrong there shows up as a one-step offset in the result. Further checks cover the zero lock-up and interleaved modes. A CRC step that used the wrong feedback bit, or XORed with a polynomial written in the same cycle, departs from the behavioural model within a few random data bits.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic {
    MODE_PRS = 1'b0,
    MODE_CRC = 1'b1
  } lfsr_mode_e;
endpackage

// File: rtl/lfsr_poly_reg.sv
module lfsr_poly_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] poly_q
);
  always_ff @(posedge clk) begin
    if (rst)     poly_q <= '0;
    else if (wr) poly_q <= wdata;
  end
endmodule

// File: rtl/lfsr_slice.sv
module lfsr_slice
  import lfsr_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  lfsr_mode_e    mode,
  input  logic [SW-1:0] seed,
  input  logic [SW-1:0] poly,
  input  logic          carry_in,
  input  logic          crc_fb,
  output logic [SW-1:0] state_q,
  output logic          tap_par,
  output logic          top_bit
);
  logic [SW-1:0] shifted;

  assign shifted = {state_q[SW-2:0], carry_in};
  assign tap_par = ^(state_q & poly);
  assign top_bit = state_q[SW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (load) begin
      state_q <= seed;
    end else if (step) begin
      if (mode == MODE_CRC) state_q <= shifted ^ (crc_fb ? poly : '0);
      else                  state_q <= shifted;
    end
  end
endmodule

// File: rtl/lfsr_seq_crc.sv
module lfsr_seq_crc
  import lfsr_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 2,
  localparam int W         = SLICE_W * NUM_SLICES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         clk_en,
  input  logic         mode_sel,
  input  logic         ser_din,
  input  logic         poly_wr,
  input  logic [W-1:0] poly_wdata,
  input  logic         seed_wr,
  input  logic [W-1:0] seed_wdata,
  output logic [W-1:0] result,
  output logic         ser_out
);
  lfsr_mode_e            mode_e;
  logic                  step;
  logic                  crc_fb;
  logic                  full_par;
  logic [W-1:0]          poly_q;
  logic [W-1:0]          state;
  logic [NUM_SLICES-1:0] slice_par;
  logic [NUM_SLICES-1:0] slice_top;
  logic [NUM_SLICES-1:0] carry;

  assign mode_e   = lfsr_mode_e'(mode_sel);
  assign step     = enable & clk_en;
  assign crc_fb   = state[W-1] ^ ser_din;
  assign full_par = ^slice_par;

  lfsr_poly_reg #(.W(W)) u_poly (
    .clk    (clk),
    .rst    (rst),
    .wr     (poly_wr),
    .wdata  (poly_wdata),
    .poly_q (poly_q)
  );

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    if (i == 0) begin : g_first
      assign carry[i] = (mode_e == MODE_PRS) ? full_par : 1'b0;
    end else begin : g_chain
      assign carry[i] = slice_top[i-1];
    end

    lfsr_slice #(.SW(SLICE_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .step     (step),
      .load     (seed_wr),
      .mode     (mode_e),
      .seed     (seed_wdata[i*SLICE_W +: SLICE_W]),
      .poly     (poly_q[i*SLICE_W +: SLICE_W]),
      .carry_in (carry[i]),
      .crc_fb   (crc_fb),
      .state_q  (state[i*SLICE_W +: SLICE_W]),
      .tap_par  (slice_par[i]),
      .top_bit  (slice_top[i])
    );
  end

  assign result  = state;
  assign ser_out = state[W-1];
endmodule

// File: rtl/lfsr_seq_crc_chk.sv
module lfsr_seq_crc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         enable,
  input logic         clk_en,
  input logic         mode_sel,
  input logic         ser_din,
  input logic         seed_wr,
  input logic [W-1:0] seed_wdata,
  input logic [W-1:0] result
);
  logic stp;
  assign stp = enable && clk_en && !seed_wr;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!(enable && clk_en) && !seed_wr) |=> $stable(result)); // R5

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    seed_wr |=> (result == $past(seed_wdata))); // R2

  AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (stp && !mode_sel && (result == '0)) |=> (result == '0)); // R7

  AST_PRS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (stp && !mode_sel) |=> (result[W-1:1] == $past(result[W-2:0]))); // R3

  AST_CRC_NO_FB: assert property (@(posedge clk) disable iff (rst)
    (stp && mode_sel && (result[W-1] == ser_din)) |=> (result == {$past(result[W-2:0]), 1'b0})); // R4
endmodule

bind lfsr_seq_crc lfsr_seq_crc_chk #(.W(SLICE_W * NUM_SLICES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .clk_en     (clk_en),
  .mode_sel   (mode_sel),
  .ser_din    (ser_din),
  .seed_wr    (seed_wr),
  .seed_wdata (seed_wdata),
  .result     (result)
);

// File: tb/lfsr_seq_crc_tb.sv
module lfsr_seq_crc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int WD_LIMIT   = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0, clk_en = 1'b0, mode_sel = 1'b0, ser_din = 1'b0;
  logic         poly_wr = 1'b0, seed_wr = 1'b0;
  logic [W-1:0] poly_wdata = '0, seed_wdata = '0;
  logic [W-1:0] result;
  logic         ser_out;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  logic [W-1:0] m_state = '0;
  logic [W-1:0] m_poly  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_seq_crc #(.SLICE_W(8), .NUM_SLICES(2)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .clk_en(clk_en), .mode_sel(mode_sel),
    .ser_din(ser_din), .poly_wr(poly_wr), .poly_wdata(poly_wdata),
    .seed_wr(seed_wr), .seed_wdata(seed_wdata), .result(result), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    logic fb;
    if (rst) begin
      m_state = '0;
      m_poly  = '0;
    end else begin
      if (seed_wr) begin
        m_state = seed_wdata;
      end else if (enable && clk_en) begin
        if (!mode_sel) begin
          fb = 1'b0;
          for (int b = 0; b < W; b++) if (m_poly[b]) fb = fb ^ m_state[b];
          m_state = (m_state << 1) | {{(W-1){1'b0}}, fb};
        end else begin
          fb = m_state[W-1] ^ ser_din;
          m_state = (m_state << 1);
          if (fb) m_state = m_state ^ m_poly;
        end
      end
      if (poly_wr) m_poly = poly_wdata;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(result == m_state, cur_req, result, m_state);
      check(ser_out == m_state[W-1], "R3 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_state[W-1]});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_seed(input logic [W-1:0] v);
    seed_wr = 1'b1; seed_wdata = v;
    tick(1);
    seed_wr = 1'b0;
  endtask

  task automatic load_poly(input logic [W-1:0] v);
    poly_wr = 1'b1; poly_wdata = v;
    tick(1);
    poly_wr = 1'b0;
  endtask

  task automatic one_step(input logic m, input logic d);
    mode_sel = m; ser_din = d; enable = 1'b1; clk_en = 1'b1;
    tick(1);
    clk_en = 1'b0;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    tick(3);
    rst = 1'b0;
    tick(1);
    cur_req = "R1";
    check(result == '0, "R1 reset result", result, '0);
    check(ser_out == 1'b0, "R1 reset ser_out", {{(W-1){1'b0}}, ser_out}, '0);

    // R2: seed write wins over a same-cycle step
    cur_req = "R2";
    enable = 1'b1; clk_en = 1'b1; mode_sel = 1'b0;
    load_seed(16'hA5C3);
    clk_en = 1'b0;
    check(result == 16'hA5C3, "R2 seed over step", result, 16'hA5C3);

    // R5: no step with enable low or clk_en low
    cur_req = "R5";
    enable = 1'b0; clk_en = 1'b1; tick(4);
    check(result == 16'hA5C3, "R5 enable low holds", result, 16'hA5C3);
    enable = 1'b1; clk_en = 1'b0; tick(4);
    check(result == 16'hA5C3, "R5 clk_en low holds", result, 16'hA5C3);

    // R3: known PRS steps
    cur_req = "R3";
    load_poly(16'hB400);
    load_seed(16'h0001);
    one_step(1'b0, 1'b0);
    check(result == 16'h0002, "R3 prs step no tap", result, 16'h0002);
    load_seed(16'h8000);
    check(ser_out == 1'b1, "R3 ser_out is msb", {{(W-1){1'b0}}, ser_out}, 16'h0001);
    one_step(1'b0, 1'b0);
    check(result == 16'h0001, "R3 prs step tap", result, 16'h0001);

    // R4: known CRC steps
    cur_req = "R4";
    load_poly(16'h1021);
    load_seed(16'h0000);
    one_step(1'b1, 1'b1);
    check(result == 16'h1021, "R4 crc fb=1", result, 16'h1021);
    one_step(1'b1, 1'b0);
    check(result == 16'h2042, "R4 crc fb=0", result, 16'h2042);
    load_seed(16'hFFFF);
    for (int i = 0; i < 200; i++) one_step(1'b1, 1'($urandom_range(0, 1)));

    // R6: poly write alone leaves register; same-cycle step uses old poly
    cur_req = "R6";
    load_poly(16'hB400);
    load_seed(16'h8000);
    load_poly(16'h0000);
    check(result == 16'h8000, "R6 poly write no state change", result, 16'h8000);
    load_poly(16'hB400);
    poly_wr = 1'b1; poly_wdata = 16'h0000;
    one_step(1'b0, 1'b0);
    poly_wr = 1'b0;
    check(result == 16'h0001, "R6 old poly on same-cycle step", result, 16'h0001);
    one_step(1'b0, 1'b0);
    check(result == 16'h0002, "R6 new poly next step", result, 16'h0002);

    // R9: carry across the slice boundary in both modes
    cur_req = "R9";
    load_seed(16'h0080);
    one_step(1'b0, 1'b0);
    check(result == 16'h0100, "R9 prs carry bit7->bit8", result, 16'h0100);
    load_seed(16'h0080);
    one_step(1'b1, 1'b0);
    check(result == 16'h0100, "R9 crc carry bit7->bit8", result, 16'h0100);

    // R10: interleaved modes
    cur_req = "R10";
    load_poly(16'h1021);
    load_seed(16'h8000);
    one_step(1'b1, 1'b0);
    check(result == 16'h1021, "R10 crc then", result, 16'h1021);
    one_step(1'b0, 1'b0);
    check(result == 16'h2043, "R10 prs after crc", result, 16'h2043);
    for (int i = 0; i < 100; i++) one_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    // R7: zero lock-up
    cur_req = "R7";
    load_poly(16'hB400);
    load_seed(16'h0000);
    mode_sel = 1'b0; clk_en = 1'b1; tick(20); clk_en = 1'b0;
    check(result == 16'h0000, "R7 zero stays zero", result, 16'h0000);
    load_seed(16'h0001);
    check(result == 16'h0001, "R7 seed recovers", result, 16'h0001);

    // R8: full period
    cur_req = "R8";
    mode_sel = 1'b0; enable = 1'b1; clk_en = 1'b1;
    cnt = 0;
    do begin
      tick(1);
      cnt++;
    end while (result != 16'h0001 && cnt < 70000);
    clk_en = 1'b0;
    check(cnt == 65535, "R8 period", W'(cnt), W'(65535));

    tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule